// File: doc/BRIEF.md
# Pipelined Synchronous SRAM Access Controller

This block is the control path of a single-port synchronous SRAM with registered inputs and registered read data, together with a behavioural word array. Every control input is taken at the rising clock edge. From those inputs the block decides whether the cycle starts a new access, continues the current burst, deselects the device or does nothing. Write data goes into the array at that same edge, one byte lane at a time or across the whole word. Read data is registered and appears one clock after the address.

Two address strobes can start an access. The processor strobe has priority over the controller strobe and is honoured only while the first chip enable is active. Continuation cycles step a two-bit wrapping burst counter in linear or interleaved order. The data pins are modelled as a separate data-out bus with an active-high drive flag. That flag is dropped on writes, on deselect, while output enable is high, and on the first read cycle out of the deselected state.

Top module: `sync_sram_ctrl`

## Requirements
- R1: When both strobes are low in the same cycle and the processor strobe is honoured, the access is a processor-strobe access. Its write controls are ignored, so the word at that address is left unchanged.
- R2: The processor strobe has no effect while `ce1_n` is high. With the controller strobe high, a deselected device stays deselected, and a selected device keeps continuing its burst.
- R3: An honoured strobe starts an access only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. Any other enable combination deselects the device, and `dout_en` is 0 after that edge.
- R4: A read address registered at edge k puts its word on `dout` with `dout_en`=1 after edge k+1, provided output enable is low.
- R5: When a read access starts from the deselected state, `dout_en` stays 0 for the cycle after the address edge, even with `oe_n` low.
- R6: `oe_n` is asynchronous. While it is high, `dout_en` is 0 and `dout` is 0 with no clock edge needed. When it goes low, a pending drive shows at once.
- R7: After any edge that performs a write, `dout_en` is 0 for the following cycle, whatever `oe_n` is.
- R8: A controller-strobe write completes in one cycle. `gw_n`=0 writes all four bytes. Otherwise `bwe_n`=0 writes byte lane i (bits 8i+7:8i) exactly where `bw_n[i]`=0. With both `gw_n` and `bwe_n` high nothing is written and the access is a read. Unselected bytes keep their value.
- R9: A processor-strobe access is a read in its first cycle. If the next cycle has no strobe and active write controls, that cycle writes to the same address when `adv_n` is high.
- R10: In a continuation cycle with `adv_n`=0, the low two address bits advance from start s to step n. With `burst_linear`=1 they become (s+n) mod 4; with `burst_linear`=0 they become s XOR n. The upper address bits do not change.
- R11: Synchronous active-high `rst` leaves the device deselected with `dout_en`=0 and `dout`=0.
- R12: In a continuation cycle with `adv_n`=1, the address is held and a read repeats the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | AW (8) | Word address; low two bits seed the burst counter |
| ce1_n | input | 1 | Chip enable 1, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Write all bytes, active low |
| bwe_n | input | 1 | Byte write qualifier, active low |
| bw_n | input | NB (4) | Per-lane byte write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| burst_linear | input | 1 | Burst order: 1 linear, 0 interleaved |
| din | input | DW (32) | Write data |
| dout | output | DW (32) | Read data, 0 when not driven |
| dout_en | output | 1 | High when the data pins would be driven |

## Verification
On every clock, the assertions check the three-state rules: no drive after a write, after a deselect or on the first read out of deselect, and no drive while output enable is high. They also check that the processor strobe wins over the controller strobe only when chip enable 1 is low. The scenario sequence is what shows that data is right. It covers the one-cycle read latency, the contents after byte-lane writes, the two-cycle processor-strobe write, both burst orders including wraparound, address hold, and the fact that ignored write controls leave stored words unchanged.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        OP_IDLE    = 3'd0,
        OP_DESEL   = 3'd1,
        OP_NEW_RD  = 3'd2,
        OP_NEW_WR  = 3'd3,
        OP_CONT_RD = 3'd4,
        OP_CONT_WR = 3'd5
    } cyc_op_e;

    function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                            input logic [1:0] step,
                                            input logic       linear);
        return linear ? (start + step) : (start ^ step);
    endfunction

endpackage

// File: rtl/sram_cycle_decode.sv
module sram_cycle_decode
    import sram_ctrl_pkg::*;
#(
    parameter int NB = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce1_n,
    input  logic          ce2,
    input  logic          ce3_n,
    input  logic          adsp_n,
    input  logic          adsc_n,
    input  logic          gw_n,
    input  logic          bwe_n,
    input  logic [NB-1:0] bw_n,
    input  logic          active,
    output cyc_op_e       op,
    output logic [NB-1:0] byte_en
);

    logic p_strobe;
    logic any_strobe;
    logic chip_sel;
    logic wr_any;

    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign byte_en[i] = !gw_n || (!bwe_n && !bw_n[i]);
    end

    assign wr_any     = |byte_en;
    assign p_strobe   = !adsp_n && !ce1_n;
    assign any_strobe = p_strobe || !adsc_n;
    assign chip_sel   = !ce1_n && ce2 && !ce3_n;

    always_comb begin
        op = OP_IDLE;
        if (any_strobe) begin
            if (!chip_sel)      op = OP_DESEL;
            else if (p_strobe)  op = OP_NEW_RD;
            else if (wr_any)    op = OP_NEW_WR;
            else                op = OP_NEW_RD;
        end else if (active) begin
            op = wr_any ? OP_CONT_WR : OP_CONT_RD;
        end
    end

    AST_PROC_STROBE_WINS: assert property (@(posedge clk) disable iff (rst)
        (!adsp_n && !adsc_n && !ce1_n && ce2 && !ce3_n) |-> (op == OP_NEW_RD)) // R1
        else $error("processor strobe lost priority");

    AST_CE1_GATES_PROC: assert property (@(posedge clk) disable iff (rst)
        (ce1_n && adsc_n) |-> (op != OP_NEW_RD && op != OP_NEW_WR && op != OP_DESEL)) // R2
        else $error("processor strobe honoured with ce1_n high");

endmodule

// File: rtl/sram_burst_ctr.sv
module sram_burst_ctr
    import sram_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       step,
    input  logic       linear,
    input  logic [1:0] start_in,
    output logic [1:0] lo_addr
);

    logic [1:0] start_d, start_q;
    logic [1:0] cnt_d, cnt_q;

    always_comb begin
        start_d = start_q;
        cnt_d   = cnt_q;
        if (load) begin
            start_d = start_in;
            cnt_d   = 2'd0;
            lo_addr = start_in;
        end else if (step) begin
            cnt_d   = cnt_q + 2'd1;
            lo_addr = burst_lo(start_q, cnt_q + 2'd1, linear);
        end else begin
            lo_addr = burst_lo(start_q, cnt_q, linear);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= 2'd0;
            cnt_q   <= 2'd0;
        end else begin
            start_q <= start_d;
            cnt_q   <= cnt_d;
        end
    end

    AST_HOLD_WITHOUT_STEP: assert property (@(posedge clk) disable iff (rst)
        (!load && !step) |=> (cnt_q == $past(cnt_q))) // R12
        else $error("burst counter moved without advance");

endmodule

// File: rtl/sram_array.sv
module sram_array #(
    parameter int DW    = 32,
    parameter int DEPTH = 256,
    localparam int NB   = DW / 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [NB-1:0] byte_en,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int i = 0; i < NB; i++) begin
                if (byte_en[i]) mem[waddr][8*i +: 8] <= wdata[8*i +: 8];
            end
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/sync_sram_ctrl.sv
module sync_sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 256,
    localparam int NB   = DW / 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int UW   = AW - 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          ce1_n,
    input  logic          ce2,
    input  logic          ce3_n,
    input  logic          adsp_n,
    input  logic          adsc_n,
    input  logic          adv_n,
    input  logic          gw_n,
    input  logic          bwe_n,
    input  logic [NB-1:0] bw_n,
    input  logic          oe_n,
    input  logic          burst_linear,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_en
);

    typedef struct packed {
        logic          sel;
        logic [UW-1:0] upper;
        logic          rd_pend;
        logic [AW-1:0] raddr;
        logic          drv;
        logic [DW-1:0] rdata;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    cyc_op_e       op;
    logic [NB-1:0] byte_en;
    logic [1:0]    lo_addr;
    logic [AW-1:0] eff_addr;
    logic [DW-1:0] arr_rdata;
    logic          is_new, is_cont, is_wr, is_rd;

    sram_cycle_decode #(.NB(NB)) u_decode (
        .clk     (clk),
        .rst     (rst),
        .ce1_n   (ce1_n),
        .ce2     (ce2),
        .ce3_n   (ce3_n),
        .adsp_n  (adsp_n),
        .adsc_n  (adsc_n),
        .gw_n    (gw_n),
        .bwe_n   (bwe_n),
        .bw_n    (bw_n),
        .active  (st_q.sel),
        .op      (op),
        .byte_en (byte_en)
    );

    assign is_new  = (op == OP_NEW_RD)  || (op == OP_NEW_WR);
    assign is_cont = (op == OP_CONT_RD) || (op == OP_CONT_WR);
    assign is_wr   = (op == OP_NEW_WR)  || (op == OP_CONT_WR);
    assign is_rd   = (op == OP_NEW_RD)  || (op == OP_CONT_RD);

    sram_burst_ctr u_burst (
        .clk      (clk),
        .rst      (rst),
        .load     (is_new),
        .step     (is_cont && !adv_n),
        .linear   (burst_linear),
        .start_in (addr[1:0]),
        .lo_addr  (lo_addr)
    );

    assign eff_addr = {(is_new ? addr[AW-1:2] : st_q.upper), lo_addr};

    sram_array #(.DW(DW), .DEPTH(DEPTH)) u_array (
        .clk     (clk),
        .we      (is_wr),
        .byte_en (byte_en),
        .waddr   (eff_addr),
        .wdata   (din),
        .raddr   (st_q.raddr),
        .rdata   (arr_rdata)
    );

    always_comb begin
        st_d         = st_q;
        st_d.rd_pend = is_rd;
        if (op == OP_DESEL) st_d.sel = 1'b0;
        else if (is_new)    st_d.sel = 1'b1;
        if (is_new) st_d.upper = addr[AW-1:2];
        if (is_rd)  st_d.raddr = eff_addr;
        st_d.drv = (op == OP_DESEL || is_wr) ? 1'b0 : st_q.rd_pend;
        if (st_q.rd_pend) st_d.rdata = arr_rdata;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign dout_en = st_q.drv && !oe_n;
    assign dout    = dout_en ? st_q.rdata : '0;

    AST_WRITE_TRISTATE: assert property (@(posedge clk) disable iff (rst)
        is_wr |=> !dout_en) // R7
        else $error("data driven after a write edge");

    AST_DESEL_TRISTATE: assert property (@(posedge clk) disable iff (rst)
        (op == OP_DESEL) |=> !dout_en) // R3
        else $error("data driven after deselect");

    AST_FIRST_READ_MASK: assert property (@(posedge clk) disable iff (rst)
        (!st_q.sel && op == OP_NEW_RD) |=> !dout_en) // R5
        else $error("first read after deselect not masked");

    AST_OE_MASK: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> (!dout_en && dout == '0)) // R6
        else $error("driving while output enable high");

endmodule

// File: tb/sync_sram_ctrl_tb.sv
module sync_sram_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 2000;

    typedef struct packed {
        logic [2:0]  cs;      // {ce1_n, ce2, ce3_n}
        logic [1:0]  strb;    // {adsp_n, adsc_n}
        logic        adv_n;
        logic [1:0]  wr;      // {gw_n, bwe_n}
        logic [3:0]  bw_n;
        logic        oe_n;
        logic        lin;
        logic [7:0]  addr;
        logic [31:0] din;
        logic        en;
        logic [31:0] dout;
        logic [7:0]  req;
    } vec_t;

    function automatic vec_t mk(logic [2:0] cs, logic [1:0] strb, logic adv,
                                logic [1:0] wr, logic [3:0] bw, logic oe, logic lin,
                                logic [7:0] a, logic [31:0] d, logic en,
                                logic [31:0] q, logic [7:0] req);
        return '{cs, strb, adv, wr, bw, oe, lin, a, d, en, q, req};
    endfunction

    localparam logic [2:0] S = 3'b010;
    localparam logic [2:0] D = 3'b101;
    localparam int NV = 33;

    localparam vec_t TBL [NV] = '{
        mk(D,      2'b11, 1, 2'b11, 4'hF, 0, 1, 8'h00, 32'h0,        0, 32'h0,        11), // 0 R11 idle
        mk(S,      2'b10, 1, 2'b01, 4'hF, 0, 1, 8'h10, 32'hA5A50F0F, 0, 32'h0,        7),  // 1 R8 full write
        mk(S,      2'b10, 1, 2'b01, 4'hF, 0, 1, 8'h11, 32'h55667788, 0, 32'h0,        8),  // 2
        mk(S,      2'b10, 1, 2'b10, 4'hA, 0, 1, 8'h11, 32'hAABBCCDD, 0, 32'h0,        8),  // 3 R8 lanes 0,2
        mk(S,      2'b10, 1, 2'b11, 4'h0, 0, 1, 8'h11, 32'h0,        0, 32'h0,        8),  // 4 bw without bwe: read
        mk(S,      2'b11, 1, 2'b11, 4'hF, 0, 1, 8'h00, 32'h0,        1, 32'h55BB77DD, 8),  // 5 R4
        mk(S,      2'b11, 1, 2'b11, 4'hF, 1, 1, 8'h00, 32'h0,        0, 32'h0,        6),  // 6 R6
        mk(3'b000, 2'b10, 1, 2'b11, 4'hF, 0, 1, 8'h00, 32'h0,        0, 32'h0,        3),  // 7 R3 ce2 low
        mk(S,      2'b01, 1, 2'b11, 4'hF, 0, 1, 8'h10, 32'h0,        0, 32'h0,        5),  // 8 R5
        mk(S,      2'b11, 1, 2'b11, 4'hF, 0, 1, 8'h00, 32'h0,        1, 32'hA5A50F0F, 4),  // 9 R4
        mk(S,      2'b00, 1, 2'b01, 4'hF, 0, 1, 8'h10, 32'hDEADBEEF, 1, 32'hA5A50F0F, 1),  // 10 R1
        mk(S,      2'b11, 1, 2'b11, 4'hF, 0, 1, 8'h00, 32'h0,        1, 32'hA5A50F0F, 1),  // 11 R1 unchanged
        mk(S,      2'b01, 1, 2'b01, 4'hF, 0, 1, 8'h20, 32'h00000001, 1, 32'hA5A50F0F, 9),  // 12 R9 first cycle
        mk(S,      2'b11, 1, 2'b01, 4'hF, 0, 1, 8'h00, 32'h13572468, 0, 32'h0,        7),  // 13 R7
        mk(S,      2'b11, 1, 2'b11, 4'hF, 0, 1, 8'h00, 32'h0,        0, 32'h0,        9),  // 14
        mk(S,      2'b11, 1, 2'b11, 4'hF, 0, 1, 8'h00, 32'h0,        1, 32'h13572468, 9),  // 15 R9
        mk(S,      2'b10, 1, 2'b01, 4'hF, 0, 1, 8'h21, 32'h00000021, 0, 32'h0,        10), // 16 R10 linear
        mk(S,      2'b11, 0, 2'b01, 4'hF, 0, 1, 8'h00, 32'h00000022, 0, 32'h0,        10), // 17
        mk(S,      2'b11, 0, 2'b01, 4'hF, 0, 1, 8'h00, 32'h00000023, 0, 32'h0,        10), // 18
        mk(S,      2'b11, 0, 2'b01, 4'hF, 0, 1, 8'h00, 32'h00000020, 0, 32'h0,        10), // 19 wrap
        mk(S,      2'b10, 1, 2'b11, 4'hF, 0, 0, 8'h22, 32'h0,        0, 32'h0,        10), // 20 interleaved
        mk(S,      2'b11, 0, 2'b11, 4'hF, 0, 0, 8'h00, 32'h0,        1, 32'h00000022, 10), // 21
        mk(S,      2'b11, 0, 2'b11, 4'hF, 0, 0, 8'h00, 32'h0,        1, 32'h00000023, 10), // 22
        mk(S,      2'b11, 0, 2'b11, 4'hF, 0, 0, 8'h00, 32'h0,        1, 32'h00000020, 10), // 23
        mk(S,      2'b11, 1, 2'b11, 4'hF, 0, 0, 8'h00, 32'h0,        1, 32'h00000021, 12), // 24 R12
        mk(S,      2'b11, 1, 2'b11, 4'hF, 0, 0, 8'h00, 32'h0,        1, 32'h00000021, 12), // 25 R12
        mk(3'b110, 2'b01, 1, 2'b11, 4'hF, 0, 1, 8'h30, 32'h0,        1, 32'h00000021, 2),  // 26 R2 active
        mk(3'b110, 2'b10, 1, 2'b11, 4'hF, 0, 1, 8'h30, 32'h0,        0, 32'h0,        3),  // 27 R3 desel
        mk(D,      2'b11, 1, 2'b11, 4'hF, 0, 1, 8'h00, 32'h0,        0, 32'h0,        3),  // 28
        mk(3'b110, 2'b01, 1, 2'b11, 4'hF, 0, 1, 8'h30, 32'h0,        0, 32'h0,        2),  // 29 R2 deselected
        mk(D,      2'b11, 1, 2'b11, 4'hF, 0, 1, 8'h00, 32'h0,        0, 32'h0,        2),  // 30
        mk(3'b011, 2'b10, 1, 2'b11, 4'hF, 0, 1, 8'h21, 32'h0,        0, 32'h0,        3),  // 31 R3 ce3_n high
        mk(S,      2'b11, 1, 2'b11, 4'hF, 0, 1, 8'h00, 32'h0,        0, 32'h0,        3)   // 32
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  addr;
    logic        ce1_n, ce2, ce3_n, adsp_n, adsc_n, adv_n, gw_n, bwe_n, oe_n, burst_linear;
    logic [3:0]  bw_n;
    logic [31:0] din;
    logic [31:0] dout;
    logic        dout_en;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_sram_ctrl u_dut (
        .clk          (clk),
        .rst          (rst),
        .addr         (addr),
        .ce1_n        (ce1_n),
        .ce2          (ce2),
        .ce3_n        (ce3_n),
        .adsp_n       (adsp_n),
        .adsc_n       (adsc_n),
        .adv_n        (adv_n),
        .gw_n         (gw_n),
        .bwe_n        (bwe_n),
        .bw_n         (bw_n),
        .oe_n         (oe_n),
        .burst_linear (burst_linear),
        .din          (din),
        .dout         (dout),
        .dout_en      (dout_en)
    );

    task automatic drive(input vec_t v);
        {ce1_n, ce2, ce3_n} = v.cs;
        {adsp_n, adsc_n}    = v.strb;
        adv_n               = v.adv_n;
        {gw_n, bwe_n}       = v.wr;
        bw_n                = v.bw_n;
        oe_n                = v.oe_n;
        burst_linear        = v.lin;
        addr                = v.addr;
        din                 = v.din;
    endtask

    task automatic check(input string tag, input logic exp_en, input logic [31:0] exp_q);
        n_run++;
        if (dout_en !== exp_en || dout !== exp_q) begin
            n_fail++;
            $display("FAIL %s: dout_en=%0b dout=%08h expected dout_en=%0b dout=%08h",
                     tag, dout_en, dout, exp_en, exp_q);
        end
    endtask

    initial begin
        rst = 1'b1;
        drive(TBL[0]);
        repeat (3) @(posedge clk);
        #1;
        check("R11 reset state", 1'b0, 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i]);
            @(posedge clk);
            #1;
            check($sformatf("R%0d row %0d", TBL[i].req, i), TBL[i].en, TBL[i].dout);
        end

        // R6: output enable acts without a clock edge
        drive(mk(S, 2'b10, 1, 2'b11, 4'hF, 0, 1, 8'h23, 32'h0, 0, 32'h0, 6));
        @(posedge clk); #1;
        drive(mk(S, 2'b11, 1, 2'b11, 4'hF, 0, 1, 8'h00, 32'h0, 0, 32'h0, 6));
        @(posedge clk); #1;
        check("R4 read of 0x23", 1'b1, 32'h00000023);
        #2 oe_n = 1'b1;
        #1 check("R6 oe high mid-cycle", 1'b0, 32'h0);
        oe_n = 1'b0;
        #1 check("R6 oe low mid-cycle", 1'b1, 32'h00000023);

        // R11: reset in the middle of a read burst
        @(posedge clk); #1;
        rst = 1'b1;
        @(posedge clk); #1;
        check("R11 reset mid burst", 1'b0, 32'h0);
        rst = 1'b0;
        drive(mk(S, 2'b11, 1, 2'b11, 4'hF, 0, 1, 8'h00, 32'h0, 0, 32'h0, 11));
        @(posedge clk); #1;
        check("R11 deselected after reset", 1'b0, 32'h0);
        @(posedge clk); #1;
        check("R11 still deselected", 1'b0, 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule